// File: doc/BRIEF.md
# SPI Slave Receive Path with Overrun and Bit-Count Checking

This block is the receiving half of an SPI slave working in clock mode 0. The SCLK, slave-select and MOSI pins enter it asynchronously. Each pin goes through a two-stage synchronizer in the system clock domain, and the block detects edges there. While the slave select is active, each rising SCLK edge shifts one MOSI bit into an assembly register, most significant bit first. When the number of bits set by a 5-bit width code has arrived, the word is pushed into a small receive FIFO. A host reads that FIFO one word per read strobe.

Two kinds of error are caught. A word that completes while the FIFO already holds its full number of unread words is discarded, and an overrun flag is latched. A transfer that ends (slave select going inactive) on a partial word latches a bit-count error flag. Both flags are sticky and are cleared by a write-one-to-clear pulse input. A port selects the active level of the slave select.

Top module: `spi_slave_rx`

## Requirements
- R1: After reset, rx_empty is 1, rx_full is 0, ovr_flag and bce_flag are 0 and rd_data is 0.
- R2: The width code selects the word size as follows: code 0 gives 32 bits, codes 1 to 7 give 8 bits, and codes 8 to 31 give that many bits. A received word appears on rd_data right-aligned and zero-extended, with the first bit received as its most significant bit.
- R3: The FIFO returns words in arrival order. Its depth DEPTH is 4 or 8. rx_full is 1 exactly when DEPTH unread words are stored, and rx_empty is 1 exactly when none are stored. A read strobe updates rd_data one cycle later.
- R4: A word that completes while rx_full is 1 is discarded, the stored words are unchanged, and ovr_flag is set. The full test uses the FIFO state from before any read in the same cycle.
- R5: ovr_flag stays 1 until a cycle with clr_ovr high clears it. If a new overrun occurs in that same cycle, the flag stays set.
- R6: When slave select goes inactive with a nonzero bit count in the current word, bce_flag is set. A transfer that ends on a word boundary leaves bce_flag unchanged.
- R7: bce_flag stays 1 until a cycle with clr_bce high clears it. If a new error occurs in that same cycle, the flag stays set.
- R8: With ss_pol at 0, slave select is active while the pin is low. With ss_pol at 1, it is active while the pin is high. SCLK edges while slave select is inactive shift in nothing.
- R9: Slave select going inactive resets the bit count, so the next transfer starts a fresh word.
- R10: A read strobe while rx_empty is 1 leaves rd_data unchanged and moves no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_pin | input | 1 | SPI serial clock, asynchronous |
| ss_pin | input | 1 | Slave select, asynchronous |
| mosi_pin | input | 1 | Serial data in, asynchronous |
| ss_pol | input | 1 | Slave-select active level (0 = low) |
| width_code | input | 5 | Word width code |
| rd_en | input | 1 | FIFO read strobe |
| rd_data | output | 32 | Last word read |
| rx_empty | output | 1 | No unread words |
| rx_full | output | 1 | DEPTH unread words stored |
| ovr_flag | output | 1 | Sticky overrun flag |
| bce_flag | output | 1 | Sticky bit-count error flag |
| clr_ovr | input | 1 | Write-one-to-clear for ovr_flag |
| clr_bce | input | 1 | Write-one-to-clear for bce_flag |

## Verification
The assertions assume three things about the pins. SCLK stays in each phase for several system clocks, so every edge survives the synchronizer. MOSI is stable around the rising SCLK edge. The width code and ss_pol change only while no transfer is in progress. The bench drives each SCLK phase for four system clocks and changes MOSI only while SCLK is low. It moves configuration only between transfers, with slave select inactive, and waits for the synchronizer to settle before it samples flags or FIFO status.

// File: rtl/spi_slave_rx.sv
module spi_slave_rx #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_pin,
  input  logic        ss_pin,
  input  logic        mosi_pin,
  input  logic        ss_pol,
  input  logic [4:0]  width_code,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        rx_empty,
  output logic        rx_full,
  output logic        ovr_flag,
  output logic        bce_flag,
  input  logic        clr_ovr,
  input  logic        clr_bce
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [2:0]    sclk_q;
  logic [1:0]    ss_q;
  logic [1:0]    mosi_q;
  logic          ss_act_q;
  logic [31:0]   shift;
  logic [5:0]    bit_cnt;
  logic [31:0]   mem [DEPTH];
  logic [LW-1:0] wr_ptr, rd_ptr;

  wire        ss_act    = (ss_q[1] == ss_pol);
  wire        ss_end    = ss_act_q & ~ss_act;
  wire        bit_take  = sclk_q[1] & ~sclk_q[2] & ss_act;
  wire [31:0] shift_nx  = {shift[30:0], mosi_q[1]};

  logic [5:0] eff_w;
  always_comb begin
    if (width_code == 5'd0)      eff_w = 6'd32;
    else if (width_code < 5'd8)  eff_w = 6'd8;
    else                         eff_w = {1'b0, width_code};
  end

  wire [31:0]   word_mask = (eff_w == 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << eff_w) - 32'd1);
  wire          word_done = bit_take && (({1'b0, bit_cnt} + 7'd1) >= {1'b0, eff_w});
  wire [LW-1:0] level     = wr_ptr - rd_ptr;

  assign rx_full  = (level == LW'(DEPTH));
  assign rx_empty = (level == '0);

  wire push = word_done & ~rx_full;
  wire pop  = rd_en & ~rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= '0;
      ss_q     <= '0;
      mosi_q   <= '0;
      ss_act_q <= 1'b0;
    end else begin
      sclk_q   <= {sclk_q[1:0], sclk_pin};
      ss_q     <= {ss_q[0], ss_pin};
      mosi_q   <= {mosi_q[0], mosi_pin};
      ss_act_q <= ss_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift   <= '0;
      bit_cnt <= '0;
    end else if (ss_end) begin
      bit_cnt <= '0;
    end else if (bit_take) begin
      shift   <= shift_nx;
      bit_cnt <= word_done ? 6'd0 : bit_cnt + 6'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= shift_nx & word_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      rd_data <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop) begin
        rd_ptr  <= rd_ptr + 1'b1;
        rd_data <= mem[rd_ptr[AW-1:0]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      bce_flag <= 1'b0;
    end else begin
      if (word_done && rx_full) ovr_flag <= 1'b1;
      else if (clr_ovr)         ovr_flag <= 1'b0;
      if (ss_end && bit_cnt != 6'd0) bce_flag <= 1'b1;
      else if (clr_bce)              bce_flag <= 1'b0;
    end
  end
endmodule

module spi_slave_rx_chk #(
  parameter int DEPTH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic [31:0] rd_data,
  input logic        rx_empty,
  input logic        rx_full,
  input logic        ovr_flag,
  input logic        bce_flag,
  input logic        clr_ovr,
  input logic        clr_bce,
  input logic        word_done,
  input logic        ss_end,
  input logic [5:0]  bit_cnt,
  input logic [$clog2(DEPTH):0] level
);
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH)+1)'(DEPTH));
  a_r3_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_empty);
  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && rx_full |=> ovr_flag);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && rx_full && !rd_en |=> rx_full);
  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && !clr_ovr |=> ovr_flag);
  a_r5_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ovr && !(word_done && rx_full) |=> !ovr_flag);
  a_r6_bce_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ss_end && bit_cnt != 6'd0 |=> bce_flag);
  a_r7_bce_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bce_flag && !clr_bce |=> bce_flag);
  a_r7_bce_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_bce && !ss_end |=> !bce_flag);
  a_r9_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ss_end |=> bit_cnt == 6'd0);
  a_r10_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rx_empty |=> $stable(rd_data));
endmodule

bind spi_slave_rx spi_slave_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data),
  .rx_empty(rx_empty), .rx_full(rx_full), .ovr_flag(ovr_flag),
  .bce_flag(bce_flag), .clr_ovr(clr_ovr), .clr_bce(clr_bce),
  .word_done(word_done), .ss_end(ss_end), .bit_cnt(bit_cnt), .level(level)
);

// File: tb/spi_slave_rx_bench.sv
module spi_slave_rx_bench;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_pin = 1'b0, ss_pin = 1'b1, mosi_pin = 1'b0, ss_pol = 1'b0;
  logic [4:0] width_code = 5'd8;
  logic rd_en = 1'b0, clr_ovr = 1'b0, clr_bce = 1'b0;
  logic [31:0] rd_data;
  logic rx_empty, rx_full, ovr_flag, bce_flag;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_slave_rx #(.DEPTH(DEPTH)) u_spi_slave_rx (
    .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .ss_pin(ss_pin),
    .mosi_pin(mosi_pin), .ss_pol(ss_pol), .width_code(width_code),
    .rd_en(rd_en), .rd_data(rd_data), .rx_empty(rx_empty), .rx_full(rx_full),
    .ovr_flag(ovr_flag), .bce_flag(bce_flag), .clr_ovr(clr_ovr), .clr_bce(clr_bce)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int eff_width(input int code);
    if (code == 0) return 32;
    if (code < 8) return 8;
    return code;
  endfunction

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ss_set(input bit active);
    ss_pin = active ? ss_pol : ~ss_pol;
    wait_clks(6);
  endtask

  task automatic send_bits(input logic [31:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sclk_pin = 1'b0;
      mosi_pin = val[i];
      wait_clks(4);
      sclk_pin = 1'b1;
      wait_clks(4);
    end
    sclk_pin = 1'b0;
    wait_clks(4);
  endtask

  task automatic xfer(input logic [31:0] val, input int n);
    ss_set(1'b1);
    send_bits(val, n);
    ss_set(1'b0);
  endtask

  task automatic read_word(output logic [31:0] d);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v, m;
    logic [31:0] vals [DEPTH];
    int w;
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(4);
    // R1
    chk("R1 empty", rx_empty, 1);
    chk("R1 full", rx_full, 0);
    chk("R1 ovr", ovr_flag, 0);
    chk("R1 bce", bce_flag, 0);
    chk("R1 rd_data", rd_data, 0);

    // R2 sweep over every width code
    for (int c = 0; c < 32; c++) begin
      width_code = 5'(c);
      w = eff_width(c);
      v = 32'hA5C3_96E1 ^ (32'(c) * 32'h0101_0137);
      m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      xfer(v, w);
      chk("R2 not empty", rx_empty, 0);
      read_word(d);
      chk($sformatf("R2 width code %0d", c), d, v & m);
      chk("R6 no bce on full word", bce_flag, 0);
    end

    // R3 fill, R4 overrun
    width_code = 5'd8;
    for (int k = 0; k < DEPTH; k++) begin
      vals[k] = 32'(8'h3C + 8'(k * 37));
      xfer(vals[k], 8);
    end
    chk("R3 full at depth", rx_full, 1);
    chk("R4 no ovr before", ovr_flag, 0);
    xfer(32'h5A, 8);
    chk("R4 ovr set", ovr_flag, 1);
    chk("R4 still full", rx_full, 1);
    wait_clks(20);
    chk("R5 ovr sticky", ovr_flag, 1);
    for (int k = 0; k < DEPTH; k++) begin
      read_word(d);
      chk($sformatf("R3/R4 order word %0d", k), d, vals[k]);
      chk("R3 not full after read", rx_full, 0);
    end
    chk("R3 empty after drain", rx_empty, 1);
    // R10
    read_word(d);
    chk("R10 empty read holds", d, vals[DEPTH-1]);
    chk("R10 still empty", rx_empty, 1);
    xfer(32'hC7, 8);
    read_word(d);
    chk("R10 pointers unmoved", d, 32'hC7);
    pulse(clr_ovr);
    wait_clks(1);
    chk("R5 ovr cleared", ovr_flag, 0);

    // R6/R7/R9 bit-count error
    width_code = 5'd16;
    xfer(32'h15, 5);
    chk("R6 bce after partial", bce_flag, 1);
    chk("R6 partial not pushed", rx_empty, 1);
    wait_clks(10);
    chk("R7 bce sticky", bce_flag, 1);
    pulse(clr_bce);
    wait_clks(1);
    chk("R7 bce cleared", bce_flag, 0);
    xfer(32'hBEEF, 16);
    chk("R9 bce clear on boundary", bce_flag, 0);
    read_word(d);
    chk("R9 fresh word after partial", d, 32'hBEEF);
    xfer(32'h1234_5, 19);
    chk("R6 bce on overlong", bce_flag, 1);
    read_word(d);
    chk("R6 first word kept", d, (32'h12345 >> 3) & 32'hFFFF);
    pulse(clr_bce);

    // R8 polarity
    ss_pol = 1'b1;
    ss_pin = 1'b0;
    wait_clks(6);
    width_code = 5'd8;
    send_bits(32'hFF, 8);
    wait_clks(4);
    chk("R8 inactive ignored", rx_empty, 1);
    chk("R8 inactive no bce", bce_flag, 0);
    xfer(32'h96, 8);
    read_word(d);
    chk("R8 active high word", d, 32'h96);
    ss_pol = 1'b0;
    ss_pin = 1'b1;
    wait_clks(6);
    xfer(32'h69, 8);
    read_word(d);
    chk("R8 active low word", d, 32'h69);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule